// File: doc/BRIEF.md
# Dual-Width Event Timer Counter

This block is an up-counter that runs either 8 or 16 bits wide. It advances on a tick strobe chosen from a bus of single-cycle enable strobes in the system clock domain. Software drives it through a synchronous write port with three write strobes: one for the control byte (width and enable), one for the tick-source select, and one for the status byte (overflow flag clear). The block drives the running count, a sticky overflow flag, and a count-active qualifier. Downstream capture and compare logic uses the qualifier to gate its activity.

Control is held in a three-state machine. `ST_OFF` is the stopped state, and the count is held at zero there. A control write that sets the enable moves `ST_OFF` to `ST_ARMED`. In `ST_ARMED` the counter waits, and the first selected tick loads zero and moves it to `ST_RUN`. In `ST_RUN` each selected tick adds one, and a tick at the all-ones value of the active width wraps the count and raises the overflow flag. A control write that clears the enable moves both `ST_ARMED` and `ST_RUN` to `ST_OFF`, and the count is zeroed on that same edge. A write that sets the enable while it is already set leaves the state where it is.

Top module: `evt_timer`

## Requirements
- R1: After reset the count is 0, the overflow flag is 0, the qualifier is low and the counter is stopped: ticks have no effect until the enable is set.
- R2: A control write with bit 3 = 1 while the enable is 0 does not change the count. The first selected tick after it loads 0, and the next selected tick gives 1.
- R3: While running, each cycle with the selected strobe high adds exactly one. Strobes on other lines of the tick bus are ignored.
- R4: The low 4 bits of a select write pick the tick-bus line with that index. Codes equal to or above the bus width select no tick.
- R5: A control write with bit 3 = 0 makes the count 0 and the qualifier low on the edge that takes the write. Ticks then have no effect.
- R6: A control write with bit 3 = 1 while the enable is already 1 does not clear the count. Counting continues from its value.
- R7: With control bit 0 = 0 (8-bit mode), a tick at 0xFF wraps the count to 0, sets the overflow flag, and counting continues. The upper byte of the count stays 0.
- R8: With control bit 0 = 1 (16-bit mode), the count passes 0xFF without overflow. A tick at 0xFFFF wraps it to 0 and sets the overflow flag.
- R9: The overflow flag clears only on a status write with bit 0 = 0. A status write with bit 0 = 1, or a change of the enable, leaves it set. A wrap in the same cycle as a clearing write leaves the flag set.
- R10: The qualifier is high whenever the enable is set, both while waiting for the first tick and while counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_ctrl | input | 1 | Write strobe for the control byte (bit 0 width, bit 3 enable) |
| wr_sel | input | 1 | Write strobe for the tick-source select (low 4 bits) |
| wr_stat | input | 1 | Write strobe for the status byte (bit 0 = 0 clears overflow) |
| wdata | input | 8 | Write data shared by the three strobes |
| tick_bus | input | 8 | Single-cycle tick strobes, one per source |
| count | output | 16 | Current count value |
| ovf_flag | output | 1 | Sticky overflow flag |
| cnt_active | output | 1 | Count-active qualifier for capture and match logic |

## Verification
The table walk changes the tick source and strobes both the chosen line and unchosen lines, including an out-of-range select code. A faulty select decode would then count ticks that should be ignored, or miss ticks that should count. The directed cases target four things. First, the tick after enable, where a design that increments at once would read 1 instead of 0. Second, a repeated enable write, which a design that restarts the count would drop to 0. Third, the 0xFF and 0xFFFF boundaries in both modes, where a wrong width would overflow too early or never. Fourth, a clearing write in the same cycle as a wrap, where a design that gives the clear priority would lose the overflow event.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } run_state_e;

    localparam int CTL_WIDE_BIT = 0;
    localparam int CTL_EN_BIT   = 3;
    localparam int STAT_OVF_BIT = 0;

endpackage

// File: rtl/evt_tick_mux.sv
module evt_tick_mux #(
    parameter int NUM_SRC = 8,
    parameter int SEL_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] tick_bus,
    input  logic [SEL_W-1:0]   sel,
    output logic               tick
);
    localparam logic [SEL_W:0] NSRC = (SEL_W+1)'(NUM_SRC);

    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SEL_W'(i)) begin
                tick = tick_bus[i];
            end
        end
    end

    // R4: codes outside the bus never yield a tick
    p_bad_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, sel} >= NSRC) |-> !tick);

endmodule

// File: rtl/evt_count_fsm.sv
module evt_count_fsm
    import evt_timer_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int NARROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_d,
    input  logic             wide,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             active,
    output logic             ovf_pulse
);
    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] inc_val;
    logic             at_top;

    always_comb begin
        at_top  = wide ? (count_q == '1) : (count_q[NARROW_W-1:0] == '1);
        inc_val = wide ? (count_q + CNT_W'(1))
                       : (CNT_W'(count_q[NARROW_W-1:0]) + CNT_W'(1));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (en_d) state_d = ST_ARMED;
            ST_ARMED: begin
                if (!en_d)     state_d = ST_OFF;
                else if (tick) state_d = ST_RUN;
            end
            ST_RUN:   if (!en_d) state_d = ST_OFF;
            default:  state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !en_d) begin
            count_q <= '0;
        end else if (tick) begin
            unique case (state_q)
                ST_ARMED: count_q <= '0;
                ST_RUN:   count_q <= at_top ? '0 : inc_val;
                default:  count_q <= '0;
            endcase
        end
    end

    always_comb begin
        count     = count_q;
        active    = (state_q != ST_OFF);
        ovf_pulse = (state_q == ST_RUN) && en_d && tick && at_top;
    end

    p_off_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |-> (count_q == '0));
    p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_d |=> (count_q == '0 && state_q == ST_OFF));
    p_first_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && en_d && tick) |=> (count_q == '0 && state_q == ST_RUN));
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && en_d && tick && !at_top) |=> (count_q == $past(count_q) + CNT_W'(1)));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && en_d && !tick) |=> $stable(count_q));
    p_narrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide && state_q == ST_RUN && en_d && tick) |=> (count_q[CNT_W-1:NARROW_W] == '0));

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int NARROW_W = 8,
    parameter int NUM_SRC  = 8,
    parameter int SEL_W    = 4,
    parameter int DATA_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ctrl,
    input  logic               wr_sel,
    input  logic               wr_stat,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_SRC-1:0] tick_bus,
    output logic [CNT_W-1:0]   count,
    output logic               ovf_flag,
    output logic               cnt_active
);
    logic             wide_q, en_q, ovf_q;
    logic [SEL_W-1:0] sel_q;
    logic             en_d, tick, ovf_pulse, clr_req;

    assign en_d    = wr_ctrl ? wdata[CTL_EN_BIT] : en_q;
    assign clr_req = wr_stat && !wdata[STAT_OVF_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q <= 1'b0;
            en_q   <= 1'b0;
            sel_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                wide_q <= wdata[CTL_WIDE_BIT];
                en_q   <= wdata[CTL_EN_BIT];
            end
            if (wr_sel) sel_q <= wdata[SEL_W-1:0];
            if (ovf_pulse)    ovf_q <= 1'b1;
            else if (clr_req) ovf_q <= 1'b0;
        end
    end

    evt_tick_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
        .clk(clk), .rst_n(rst_n), .tick_bus(tick_bus), .sel(sel_q), .tick(tick)
    );

    evt_count_fsm #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en_d(en_d), .wide(wide_q), .tick(tick),
        .count(count), .active(cnt_active), .ovf_pulse(ovf_pulse)
    );

    assign ovf_flag = ovf_q;

    p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> ovf_q);
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr_req) |=> ovf_q);
    p_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |-> cnt_active);

endmodule

// File: tb/evt_timer_tb_top.sv
module evt_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_ctrl = 1'b0, wr_sel = 1'b0, wr_stat = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  tick_bus = '0;
    logic [15:0] count;
    logic        ovf_flag, cnt_active;
    int          total = 0;
    int          bad = 0;

    always #10 clk = ~clk;

    evt_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_sel(wr_sel),
        .wr_stat(wr_stat), .wdata(wdata), .tick_bus(tick_bus),
        .count(count), .ovf_flag(ovf_flag), .cnt_active(cnt_active)
    );

    // fields: [23:20] select, [19:16] strobed line, [15:8] ticks, [7:0] expected count
    localparam logic [23:0] VEC [0:6] = '{
        24'h220100, 24'h220505, 24'h250305, 24'h550409,
        24'hC50309, 24'hC70209, 24'h770A13
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int which, input logic [7:0] d);
        @(negedge clk);
        wdata = d;
        if (which == 0) wr_ctrl = 1'b1;
        else if (which == 1) wr_sel = 1'b1;
        else wr_stat = 1'b1;
        @(negedge clk);
        wr_ctrl = 1'b0; wr_sel = 1'b0; wr_stat = 1'b0;
    endtask

    task automatic pulse(input int src, input int n);
        if (n > 0) begin
            @(negedge clk);
            tick_bus = '0;
            tick_bus[src] = 1'b1;
            repeat (n) @(negedge clk);
            tick_bus = '0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count", count, 16'h0);
        chk("R1 ovf", {15'b0, ovf_flag}, 16'h0);
        chk("R1 active", {15'b0, cnt_active}, 16'h0);
        wr(1, 8'h02);
        pulse(2, 3);
        chk("R1 stopped", count, 16'h0);

        wr(0, 8'h08);
        chk("R2 no change", count, 16'h0);
        chk("R10 armed active", {15'b0, cnt_active}, 16'h1);
        for (int k = 0; k < 7; k++) begin
            wr(1, {4'h0, VEC[k][23:20]});
            pulse(int'(VEC[k][19:16]), int'(VEC[k][15:8]));
            chk($sformatf("R2/R3/R4 vec%0d", k), count, {8'h0, VEC[k][7:0]});
        end
        chk("R10 run active", {15'b0, cnt_active}, 16'h1);

        wr(0, 8'h08);
        chk("R6 rewrite", count, 16'h13);
        pulse(7, 1);
        chk("R6 continue", count, 16'h14);

        wr(0, 8'h00);
        chk("R5 zero", count, 16'h0);
        chk("R5 inactive", {15'b0, cnt_active}, 16'h0);
        pulse(7, 3);
        chk("R5 ignore ticks", count, 16'h0);

        wr(0, 8'h08);
        pulse(7, 1);
        pulse(7, 255);
        chk("R7 at top", count, 16'h00FF);
        chk("R7 no ovf yet", {15'b0, ovf_flag}, 16'h0);
        pulse(7, 1);
        chk("R7 wrap", count, 16'h0);
        chk("R7 ovf", {15'b0, ovf_flag}, 16'h1);
        pulse(7, 1);
        chk("R7 continues", count, 16'h1);

        wr(2, 8'h01);
        chk("R9 write one", {15'b0, ovf_flag}, 16'h1);
        wr(0, 8'h00);
        chk("R9 disable keeps", {15'b0, ovf_flag}, 16'h1);
        wr(2, 8'h00);
        chk("R9 cleared", {15'b0, ovf_flag}, 16'h0);
        wr(0, 8'h08);
        pulse(7, 256);
        chk("R9 setup", count, 16'h00FF);
        @(negedge clk);
        tick_bus = 8'h80; wdata = 8'h00; wr_stat = 1'b1;
        @(negedge clk);
        tick_bus = '0; wr_stat = 1'b0;
        chk("R9 set beats clear", {15'b0, ovf_flag}, 16'h1);
        chk("R9 wrap count", count, 16'h0);

        wr(0, 8'h00);
        wr(2, 8'h00);
        wr(0, 8'h09);
        pulse(7, 1);
        pulse(7, 300);
        chk("R8 past 0xFF", count, 16'd300);
        chk("R8 no early ovf", {15'b0, ovf_flag}, 16'h0);
        pulse(7, 65235);
        chk("R8 at top", count, 16'hFFFF);
        pulse(7, 1);
        chk("R8 wrap", count, 16'h0);
        chk("R8 ovf", {15'b0, ovf_flag}, 16'h1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule